// File: doc/BRIEF.md
# Single-Wire Pulse-Width LED Encoder

This block drives a daisy chain of addressable RGB LEDs over one output wire. Each data bit occupies a fixed cell of ticks. The cell starts high, and the length of that high pulse carries the bit value. Pixels arrive as 24-bit words over a ready/valid stream, already in green-red-blue byte order. The encoder sends their bits back to back, one pixel after another.

All timing comes from a clock-enable `tick` that pulses at a fixed rate; 8 MHz is the intended rate. Counters advance only on cycles where `tick` is high, so the system clock can be any faster frequency. A pixel marked as the last of a frame starts a low "latch" interval, and the chain displays the frame at the end of it. The latch length is a configuration input. A value too short for the LEDs to latch raises a configuration error, and the output stays disabled while that error holds. If the stream runs dry in the middle of a frame, the line stays low and a sticky underrun flag is set.

Top module: `pwled_serializer`

## Requirements
- R1: After reset the line is low, `underrun` is 0 and the block is idle. `pix_ready` is 1 and `cfg_err` is 0 whenever the configured latch length is valid.
- R2: Every bit cell lasts exactly 10 ticks. A 1 bit drives the line high for the first 6 ticks of its cell and a 0 bit for the first 3. The rest of the cell is low.
- R3: Bits leave most-significant first, from `pix_data[23]` down to `pix_data[0]`. The green byte is `[23:16]`, red is `[15:8]` and blue is `[7:0]`.
- R4: `pix_ready` is high when the block is idle. It is also high during the tick that ends the final cell of a pixel not marked last, so the next pixel's first cell follows with no gap. At all other times it is low.
- R5: After the final cell of a pixel accepted with `pix_last`=1, the line stays low and `pix_ready` stays low for `latch_ticks` ticks. The block then returns to idle.
- R6: The minimum valid latch length is 401 ticks, which is more than 50 µs at 125 ns per tick. While `latch_ticks` < 401, `cfg_err` is 1, the line is low and `pix_ready` is 0, and any frame in progress is dropped.
- R7: If a pixel not marked last finishes while `pix_valid` is 0, `underrun` goes to 1 and stays there until reset. The line stays low and the block goes idle, ready for the next pixel.
- R8: Cell and latch timing advance only on cycles where `tick` is 1. While `tick` stays 0 the line holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable, one pulse per 125 ns timing tick |
| latch_ticks | input | 16 | Length of the low interval after a frame, in ticks |
| pix_data | input | 24 | Pixel in green-red-blue order, green in the top byte |
| pix_last | input | 1 | Marks the pixel as the final one of a frame |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| led_out | output | 1 | Encoded serial line to the LED chain |
| cfg_err | output | 1 | Latch length below the minimum; output disabled |
| underrun | output | 1 | Sticky flag: stream ran dry mid-frame |

## Verification
The bench builds the block with its default parameters: 24-bit pixels, 10-tick cells, high widths of 6 and 3 ticks, and a minimum latch of 401 ticks. The exact latch boundary and the configuration error are therefore the real ones. The bench varies the tick spacing over 1, 2 and 3 clocks. It also stalls the tick, which lets it check cell widths, back-to-back pixel joins and the latch interval against a tick-counting reference model at several ratios of tick to clock. Directed cases decode the pulse train back into pixel words, run the stream dry to raise an underrun, and drop the latch length mid-frame to force an abort.

// File: rtl/pwled_pkg.sv
package pwled_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_LATCH = 2'd2
   } pw_state_t;
endpackage

// File: rtl/pwled_cell_timer.sv
module pwled_cell_timer #(
   parameter int CELL_TICKS = 10,
   parameter int ONE_HIGH   = 6,
   parameter int ZERO_HIGH  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic bit_val,
   output logic cell_end,
   output logic line_hi
);
   localparam int CW = $clog2(CELL_TICKS + 1);
   localparam logic [CW-1:0] LAST_C = CW'(CELL_TICKS - 1);
   localparam logic [CW-1:0] ONE_C  = CW'(ONE_HIGH);
   localparam logic [CW-1:0] ZERO_C = CW'(ZERO_HIGH);

   logic [CW-1:0] cnt;
   logic [CW-1:0] hi_len;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= (cnt == LAST_C) ? '0 : cnt + CW'(1);
      end
   end

   always_comb begin
      hi_len   = bit_val ? ONE_C : ZERO_C;
      cell_end = run && tick && (cnt == LAST_C);
      line_hi  = run && (cnt < hi_len);
   end

   // R2: the tick count never leaves the cell
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_C);

   // R8: without a tick the count holds, unless the cell is abandoned
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> (cnt == $past(cnt) || cnt == '0));
endmodule

// File: rtl/pwled_pixel_shift.sv
module pwled_pixel_shift #(
   parameter int PIX_W     = 24,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PIX_W-1:0] pix_in,
   input  logic             last_in,
   input  logic             advance,
   output logic             cur_bit,
   output logic             final_bit,
   output logic             frame_last
);
   localparam int IW = $clog2(PIX_W);
   localparam logic [IW-1:0] IDX_END = IW'(PIX_W - 1);

   logic [PIX_W-1:0] sreg;
   logic [IW-1:0]    idx;
   logic [PIX_W-1:0] shifted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shifted = {sreg[PIX_W-2:0], 1'b0};
         assign cur_bit = sreg[PIX_W-1];
      end else begin : g_lsb
         assign shifted = {1'b0, sreg[PIX_W-1:1]};
         assign cur_bit = sreg[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg       <= '0;
         idx        <= '0;
         frame_last <= 1'b0;
      end else if (load) begin
         sreg       <= pix_in;
         idx        <= '0;
         frame_last <= last_in;
      end else if (advance) begin
         sreg <= shifted;
         idx  <= (idx == IDX_END) ? '0 : idx + IW'(1);
      end
   end

   assign final_bit = (idx == IDX_END);

   // R3: bit position stays inside the pixel
   p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_END);
endmodule

// File: rtl/pwled_latch_timer.sv
module pwled_latch_timer #(
   parameter int LATCH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [LATCH_W-1:0] limit,
   output logic               done
);
   logic [LATCH_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + LATCH_W'(1);
      end
   end

   assign done = run && tick &&
      (({1'b0, cnt} + {{LATCH_W{1'b0}}, 1'b1}) >= {1'b0, limit});
endmodule

// File: rtl/pwled_serializer.sv
module pwled_serializer #(
   parameter int PIX_W           = 24,
   parameter int CELL_TICKS      = 10,
   parameter int ONE_HIGH        = 6,
   parameter int ZERO_HIGH       = 3,
   parameter int LATCH_W         = 16,
   parameter int MIN_LATCH_TICKS = 401,
   parameter bit MSB_FIRST       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [LATCH_W-1:0] latch_ticks,
   input  logic [PIX_W-1:0]   pix_data,
   input  logic               pix_last,
   input  logic               pix_valid,
   output logic               pix_ready,
   output logic               led_out,
   output logic               cfg_err,
   output logic               underrun
);
   import pwled_pkg::*;

   localparam logic [LATCH_W-1:0] MIN_C = LATCH_W'(MIN_LATCH_TICKS);

   generate
      if (ZERO_HIGH < 1) begin : g_bad_zero
         $error("zero-bit high width must be at least one tick");
      end
      if (ONE_HIGH <= ZERO_HIGH) begin : g_bad_one
         $error("one-bit high width must exceed zero-bit high width");
      end
      if (ONE_HIGH >= CELL_TICKS) begin : g_bad_cell
         $error("one-bit high width must leave a low part in the cell");
      end
      if (PIX_W < 2) begin : g_bad_pix
         $error("pixel width must be at least two bits");
      end
      if (MIN_LATCH_TICKS < 1 || MIN_LATCH_TICKS >= (1 << LATCH_W)) begin : g_bad_latch
         $error("minimum latch length must fit the latch field");
      end
   endgenerate

   pw_state_t state, state_nx;
   logic cfg_bad, cell_end, line_hi, cur_bit, final_bit, frame_last;
   logic latch_done, pixel_end, accept, starve;

   assign cfg_bad = (latch_ticks < MIN_C);

   pwled_cell_timer #(
      .CELL_TICKS (CELL_TICKS),
      .ONE_HIGH   (ONE_HIGH),
      .ZERO_HIGH  (ZERO_HIGH)
   ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (state == ST_SEND),
      .bit_val  (cur_bit),
      .cell_end (cell_end),
      .line_hi  (line_hi)
   );

   pwled_pixel_shift #(
      .PIX_W     (PIX_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .pix_in     (pix_data),
      .last_in    (pix_last),
      .advance    (cell_end),
      .cur_bit    (cur_bit),
      .final_bit  (final_bit),
      .frame_last (frame_last)
   );

   pwled_latch_timer #(
      .LATCH_W (LATCH_W)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_LATCH),
      .tick  (tick),
      .limit (latch_ticks),
      .done  (latch_done)
   );

   always_comb begin
      pixel_end = cell_end && final_bit;
      pix_ready = !cfg_bad &&
                  ((state == ST_IDLE) ||
                   ((state == ST_SEND) && pixel_end && !frame_last));
      accept    = pix_valid && pix_ready;
      starve    = !cfg_bad && (state == ST_SEND) && pixel_end &&
                  !frame_last && !pix_valid;
   end

   always_comb begin
      state_nx = state;
      if (cfg_bad) begin
         state_nx = ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:  if (accept) state_nx = ST_SEND;
            ST_SEND: begin
               if (pixel_end) begin
                  if (frame_last)  state_nx = ST_LATCH;
                  else if (accept) state_nx = ST_SEND;
                  else             state_nx = ST_IDLE;
               end
            end
            ST_LATCH: if (latch_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         underrun <= 1'b0;
      end else begin
         state <= state_nx;
         if (starve) underrun <= 1'b1;
      end
   end

   assign led_out = line_hi && !cfg_bad;
   assign cfg_err = cfg_bad;

   // R1: an idle line is low
   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !led_out);

   // R4: no pixel is taken in the middle of a pixel
   p_no_take_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SEND) && !cell_end) |-> !pix_ready);

   // R5: latch interval is quiet
   p_latch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LATCH) |-> (!led_out && !pix_ready));

   // R6: a bad latch length disables the line and the stream
   p_cfg_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!led_out && !pix_ready));

   // R6: a bad latch length drops any frame in progress
   p_cfg_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> (state == ST_IDLE));

   // R7: underrun is sticky
   p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
endmodule

// File: tb/pwled_serializer_tb_top.sv
module pwled_serializer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] latch_ticks = 16'd401;
   logic [23:0] pix_data = '0;
   logic        pix_last = 1'b0;
   logic        pix_valid = 1'b0;
   logic        pix_ready, led_out, cfg_err, underrun;

   always #4 clk = ~clk;

   pwled_serializer dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .latch_ticks (latch_ticks),
      .pix_data    (pix_data),
      .pix_last    (pix_last),
      .pix_valid   (pix_valid),
      .pix_ready   (pix_ready),
      .led_out     (led_out),
      .cfg_err     (cfg_err),
      .underrun    (underrun)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // tick generator
   int tp = 1;
   bit tick_en = 1'b1;
   int tcnt = 0;
   always @(posedge clk) begin
      if (!tick_en) begin
         tick <= 1'b0;
         tcnt <= 0;
      end else if (tcnt >= tp - 1) begin
         tick <= 1'b1;
         tcnt <= 0;
      end else begin
         tick <= 1'b0;
         tcnt <= tcnt + 1;
      end
   end

   // reference model: counts ticks, reads ports only
   int m_mode = 0, m_bit = 0, m_tk = 0, m_lat = 0;
   logic [23:0] m_pix = '0;
   bit m_last = 1'b0, m_under = 1'b0, acc_flag = 1'b0;

   function automatic bit m_cfgbad();
      return latch_ticks < 16'd401;
   endfunction
   function automatic bit m_ready();
      return !m_cfgbad() && (m_mode == 0 ||
         (m_mode == 1 && tick && m_tk == 9 && m_bit == 23 && !m_last));
   endfunction
   function automatic bit m_line();
      return !m_cfgbad() && m_mode == 1 &&
             m_tk < (m_pix[23 - m_bit] ? 6 : 3);
   endfunction

   always @(posedge clk) begin
      bit acc;
      acc_flag = pix_valid && pix_ready;
      acc = pix_valid && m_ready();
      if (!rst_n) begin
         m_mode = 0; m_bit = 0; m_tk = 0; m_lat = 0; m_under = 0; m_last = 0;
      end else if (m_cfgbad()) begin
         m_mode = 0; m_tk = 0; m_lat = 0;
      end else begin
         case (m_mode)
            0: if (acc) begin
                  m_mode = 1; m_pix = pix_data; m_last = pix_last;
                  m_bit = 0; m_tk = 0;
               end
            1: if (tick) begin
                  if (m_tk == 9) begin
                     m_tk = 0;
                     if (m_bit == 23) begin
                        if (m_last) begin
                           m_mode = 2; m_lat = 0;
                        end else if (pix_valid) begin
                           m_pix = pix_data; m_last = pix_last; m_bit = 0;
                        end else begin
                           m_under = 1; m_mode = 0;
                        end
                     end else begin
                        m_bit++;
                     end
                  end else begin
                     m_tk++;
                  end
               end
            default: if (tick) begin
                  m_lat++;
                  if (m_lat >= latch_ticks) m_mode = 0;
               end
         endcase
      end
   end

   // per-cycle comparison and pulse monitor
   int cyc = 0, run_len = 0, hi_cnt = 0;
   bit prev_led = 1'b0;
   int widths[$];
   int rises[$];
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk("R2", "led_out", led_out, m_line());
         chk(m_mode == 2 ? "R5" : "R4", "pix_ready", pix_ready, m_ready());
         chk("R7", "underrun", underrun, m_under);
         chk("R6", "cfg_err", cfg_err, m_cfgbad());
      end
      if (led_out) hi_cnt++;
      if (led_out && !prev_led) begin
         rises.push_back(cyc);
         run_len = 0;
      end
      if (led_out) run_len++;
      if (!led_out && prev_led) widths.push_back(run_len);
      prev_led = led_out;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   logic [23:0] fq[$];

   task automatic play_frame(input bit end_frame);
      @(posedge clk); #1;
      foreach (fq[i]) begin
         pix_valid = 1'b1;
         pix_data  = fq[i];
         pix_last  = end_frame && (i == fq.size() - 1);
         do begin @(posedge clk); #1; end while (!acc_flag);
      end
      pix_valid = 1'b0;
      pix_last  = 1'b0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [23:0] dec;
      int base;
      logic v0;

      // R1 reset state
      do_reset();
      wait_cyc(1);
      chk("R1", "led_out after reset", led_out, 0);
      chk("R1", "underrun after reset", underrun, 0);
      chk("R1", "pix_ready after reset", pix_ready, 1);
      chk("R1", "cfg_err after reset", cfg_err, 0);

      // R2/R3/R4 tick every clock, two-pixel frame
      tp = 1;
      widths.delete(); rises.delete();
      fq = '{24'h800000, 24'hA5C3F0};
      play_frame(1'b1);
      wait_cyc(1000);
      chk("R3", "pulse count", widths.size(), 48);
      if (widths.size() == 48 && rises.size() == 48) begin
         chk("R2", "one-bit high width", widths[0], 6);
         chk("R2", "zero-bit high width", widths[1], 3);
         chk("R2", "cell period", rises[1] - rises[0], 10);
         chk("R4", "pixel join period", rises[24] - rises[23], 10);
         for (int p = 0; p < 2; p++) begin
            base = p * 24;
            dec = '0;
            for (int b = 0; b < 24; b++) dec = {dec[22:0], widths[base + b] == 6};
            chk("R3", "decoded pixel", dec, p == 0 ? 24'h800000 : 24'hA5C3F0);
         end
      end

      // R5 three pixels, tick every third clock
      tp = 3;
      fq = '{24'h00FF00, 24'hFF0000, 24'h0000FF};
      play_frame(1'b1);
      wait_cyc(900);
      chk("R5", "line low in latch", led_out, 0);
      chk("R5", "ready low in latch", pix_ready, 0);
      wait_cyc(1500);
      chk("R5", "ready after latch", pix_ready, 1);

      // R7 underrun
      tp = 1;
      fq = '{24'h0F0F0F};
      play_frame(1'b0);
      wait_cyc(300);
      chk("R7", "underrun set", underrun, 1);
      chk("R7", "line low after underrun", led_out, 0);
      chk("R7", "ready after underrun", pix_ready, 1);
      fq = '{24'h123456};
      play_frame(1'b1);
      wait_cyc(700);
      chk("R7", "underrun sticky", underrun, 1);
      do_reset();
      wait_cyc(1);
      chk("R1", "reset clears underrun", underrun, 0);

      // R8 tick stall holds the line
      fq = '{24'hFFFFFF};
      play_frame(1'b1);
      wait_cyc(2);
      tick_en = 1'b0;
      wait_cyc(2);
      v0 = led_out;
      wait_cyc(30);
      chk("R8", "line held without tick", led_out, v0);
      chk("R8", "held level high", v0, 1);
      tick_en = 1'b1;
      wait_cyc(800);

      // R6 bad latch length
      @(posedge clk); #1 latch_ticks = 16'd100;
      wait_cyc(2);
      chk("R6", "cfg_err on short latch", cfg_err, 1);
      chk("R6", "ready blocked", pix_ready, 0);
      hi_cnt = 0;
      @(posedge clk); #1 begin pix_valid = 1'b1; pix_data = 24'hFFFFFF; pix_last = 1'b1; end
      wait_cyc(50);
      chk("R6", "no pulses while disabled", hi_cnt, 0);
      @(posedge clk); #1 begin pix_valid = 1'b0; latch_ticks = 16'd400; end
      wait_cyc(2);
      chk("R6", "cfg_err at 400", cfg_err, 1);
      @(posedge clk); #1 latch_ticks = 16'd401;
      wait_cyc(2);
      chk("R6", "cfg_err at 401", cfg_err, 0);
      fq = '{24'hFFFFFF};
      play_frame(1'b1);
      wait_cyc(2);
      @(posedge clk); #1 latch_ticks = 16'd100;
      wait_cyc(1);
      chk("R6", "abort drops line", led_out, 0);
      @(posedge clk); #1 latch_ticks = 16'd401;
      wait_cyc(3);
      chk("R6", "abort returns idle", pix_ready, 1);
      chk("R6", "idle line low", led_out, 0);

      // mixed pattern, tick every second clock, longer latch
      tp = 2;
      @(posedge clk); #1 latch_ticks = 16'd420;
      fq = '{24'hFFFFFF, 24'h000000};
      play_frame(1'b1);
      wait_cyc(2000);
      chk("R5", "idle after long latch", pix_ready, 1);

      finished = 1'b1;
      summary();
   end
endmodule